// File: doc/BRIEF.md
# I2C Register-Write Target

This block is the control-port receiver of a larger chip. It listens on the two wires of an I2C bus and lets a bus controller load a small file of 8-bit control registers. It only accepts writes. A transaction opens with a start condition and a device byte. That byte carries a 7-bit device address, fixed by a parameter, and a direction bit of zero. A pointer byte follows, and then any number of data bytes. The block acknowledges each byte it accepts by pulling the data line low for the ninth clock.

Both bus wires pass through two-flop synchronisers and are sampled on the system clock. Start and stop conditions are found as data-line edges while the clock line is high. Data bits are taken on clock-line rises. The pointer is five bits wide. Each data byte is stored at the pointer, and the pointer then moves on by one. After the last register it returns to zero, so a long burst overwrites the earliest registers again. The register contents leave the block as one flat parallel bus, and the rest of the chip reads them from there.

Top module: `i2c_regwrite_slave`

## Requirements
- R1: While reset is high, and on the first cycle after it, all nine registers read zero and `sda_oe` is 0.
- R2: A device byte equal to {DEV_ADDR, 1'b0} (address in bits 7..1, direction in bit 0) is acknowledged: `sda_oe` is 1 while SCL is high on the ninth clock.
- R3: A device byte with another address, or with bit 0 set, gets no acknowledge. Every byte after it, up to the next start, is neither acknowledged nor stored.
- R4: In the pointer byte only bits 4..0 count. Bits 7..5 have no effect on where data lands, and the pointer byte is acknowledged.
- R5: Each data byte is received MSB first, acknowledged, and written into the register the pointer selects. Register k appears on `regs_flat[8k+7:8k]`.
- R6: After each data byte the pointer rises by one, so consecutive bytes fill consecutive registers.
- R7: A data byte stored at register 8 moves the pointer to 0. Later bytes in the same transaction overwrite registers 0, 1 and so on.
- R8: A data byte sent while the pointer is above 8 is acknowledged but changes no register. The pointer then moves to 0.
- R9: A stop condition in the middle of a byte throws the partial byte away. A repeated start in the middle of a byte also throws it away and starts address matching again.
- R10: `sda_oe` changes only after an SCL falling edge (or a start or stop), and it is back at 0 once the ninth clock has fallen.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Bus clock line as seen on the pin |
| sda_in | input | 1 | Bus data line as seen on the pin |
| sda_oe | output | 1 | 1 pulls the data line low (open drain) |
| regs_flat | output | NREG*8 | All registers, register k in bits 8k+7..8k |

## Verification
The assertions rely on a legal bus. SDA may change only while SCL is low, except when it forms a start or a stop, and every SCL level must last several system clocks so that both wires pass through the synchronisers in order. The bench models the bus as a wired AND of the controller and the block. Each quarter of a bit period lasts ten system clocks, and the bench changes SDA only in the quarter where SCL is low. Under those rules the edge-timing and register-hold properties stay meaningful.

// File: rtl/i2cw_pkg.sv
package i2cw_pkg;

    localparam int PTR_W  = 5;
    localparam int DATA_W = 8;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_DEV,
        PH_PTR,
        PH_DATA
    } phase_e;

    typedef struct packed {
        logic start;
        logic stop;
        logic scl_rise;
        logic scl_fall;
        logic sda;
    } bus_ev_t;

    typedef struct packed {
        logic              en;
        logic [PTR_W-1:0]  addr;
        logic [DATA_W-1:0] data;
    } wr_req_t;

    // Device byte: address in bits 7..1, direction in bit 0 (0 = write)
    function automatic logic dev_match(input logic [DATA_W-1:0] b,
                                       input logic [6:0] dev);
        return (b[7:1] == dev) && (b[0] == 1'b0);
    endfunction

endpackage

// File: rtl/i2cw_sync.sv
module i2cw_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] pipe [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) begin
                    pipe[s] <= '1;
                end else if (s == 0) begin
                    pipe[s] <= d;
                end else begin
                    pipe[s] <= pipe[(s == 0) ? 0 : s-1];
                end
            end
        end
    endgenerate

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/i2cw_cond.sv
module i2cw_cond
    import i2cw_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_s,
    input  logic    sda_s,
    output bus_ev_t ev
);
    logic scl_q, sda_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    always_comb begin
        ev.start    = scl_s & scl_q & sda_q & ~sda_s;
        ev.stop     = scl_s & scl_q & ~sda_q & sda_s;
        ev.scl_rise = scl_s & ~scl_q;
        ev.scl_fall = ~scl_s & scl_q;
        ev.sda      = sda_s;
    end
endmodule

// File: rtl/i2cw_proto.sv
module i2cw_proto
    import i2cw_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h48,
    parameter int         NREG     = 9
) (
    input  logic    clk,
    input  logic    rst,
    input  bus_ev_t ev,
    output logic    sda_oe,
    output phase_e  phase,
    output wr_req_t wr
);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(NREG - 1);
    localparam logic [3:0]       ACK_SLOT = 4'd8;
    localparam logic [3:0]       ACK_DONE = 4'd9;

    logic [3:0]        bit_cnt;
    logic [DATA_W-1:0] shreg;
    logic [PTR_W-1:0]  ptr;

    function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
        return (p >= LAST) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            phase   <= PH_IDLE;
            bit_cnt <= '0;
            shreg   <= '0;
            ptr     <= '0;
            sda_oe  <= 1'b0;
            wr      <= '0;
        end else begin
            wr.en <= 1'b0;
            if (ev.start) begin
                phase   <= PH_DEV;
                bit_cnt <= '0;
                sda_oe  <= 1'b0;
            end else if (ev.stop) begin
                phase   <= PH_IDLE;
                bit_cnt <= '0;
                sda_oe  <= 1'b0;
            end else if (phase != PH_IDLE) begin
                if (ev.scl_rise) begin
                    if (bit_cnt < ACK_SLOT) begin
                        shreg <= {shreg[DATA_W-2:0], ev.sda};
                    end
                    bit_cnt <= bit_cnt + 4'd1;
                end else if (ev.scl_fall) begin
                    if (bit_cnt == ACK_SLOT) begin
                        unique case (phase)
                            PH_DEV: begin
                                if (dev_match(shreg, DEV_ADDR)) begin
                                    sda_oe <= 1'b1;
                                end else begin
                                    phase   <= PH_IDLE;
                                    bit_cnt <= '0;
                                end
                            end
                            PH_PTR: begin
                                ptr    <= shreg[PTR_W-1:0];
                                sda_oe <= 1'b1;
                            end
                            PH_DATA: begin
                                sda_oe  <= 1'b1;
                                wr.en   <= (ptr <= LAST);
                                wr.addr <= ptr;
                                wr.data <= shreg;
                                ptr     <= step(ptr);
                            end
                            default: ;
                        endcase
                    end else if (bit_cnt == ACK_DONE) begin
                        sda_oe  <= 1'b0;
                        bit_cnt <= '0;
                        if (phase == PH_DEV) begin
                            phase <= PH_PTR;
                        end else if (phase == PH_PTR) begin
                            phase <= PH_DATA;
                        end
                    end
                end
            end
        end
    end
endmodule

// File: rtl/i2cw_regbank.sv
module i2cw_regbank
    import i2cw_pkg::*;
#(
    parameter int NREG = 9
) (
    input  logic                   clk,
    input  logic                   rst,
    input  wr_req_t                wr,
    output logic [NREG*DATA_W-1:0] regs_flat
);
    generate
        for (genvar g = 0; g < NREG; g++) begin : g_reg
            logic [DATA_W-1:0] r;
            always_ff @(posedge clk) begin
                if (rst) begin
                    r <= '0;
                end else if (wr.en && (wr.addr == PTR_W'(g))) begin
                    r <= wr.data;
                end
            end
            assign regs_flat[g*DATA_W +: DATA_W] = r;
        end
    endgenerate
endmodule

// File: rtl/i2c_regwrite_slave.sv
module i2c_regwrite_slave
    import i2cw_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h48,
    parameter int         NREG     = 9
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   scl_in,
    input  logic                   sda_in,
    output logic                   sda_oe,
    output logic [NREG*DATA_W-1:0] regs_flat
);
    logic [1:0] pins_s;
    bus_ev_t    ev;
    phase_e     phase;
    wr_req_t    wr;

    i2cw_sync #(.W(2), .STAGES(2)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({scl_in, sda_in}),
        .q   (pins_s)
    );

    i2cw_cond u_cond (
        .clk   (clk),
        .rst   (rst),
        .scl_s (pins_s[1]),
        .sda_s (pins_s[0]),
        .ev    (ev)
    );

    i2cw_proto #(.DEV_ADDR(DEV_ADDR), .NREG(NREG)) u_proto (
        .clk    (clk),
        .rst    (rst),
        .ev     (ev),
        .sda_oe (sda_oe),
        .phase  (phase),
        .wr     (wr)
    );

    i2cw_regbank #(.NREG(NREG)) u_bank (
        .clk       (clk),
        .rst       (rst),
        .wr        (wr),
        .regs_flat (regs_flat)
    );
endmodule

// File: rtl/i2cw_checker.sv
module i2cw_checker
    import i2cw_pkg::*;
#(
    parameter int NREG = 9
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   sda_oe,
    input bus_ev_t                ev,
    input phase_e                 phase,
    input wr_req_t                wr,
    input logic [NREG*DATA_W-1:0] regs_flat
);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(NREG - 1);

    p_reset_clears_r1: assert property (@(posedge clk)
        rst |=> (regs_flat == '0 && sda_oe == 1'b0));

    p_ack_on_fall_r10: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_oe) |-> $past(ev.scl_fall));

    p_ack_release_r10: assert property (@(posedge clk) disable iff (rst)
        $fell(sda_oe) |-> $past(ev.scl_fall || ev.start || ev.stop));

    p_idle_silent_r3: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_IDLE) |-> !sda_oe);

    p_regs_hold_r3: assert property (@(posedge clk) disable iff (rst)
        !$past(wr.en) |-> $stable(regs_flat));

    p_write_in_range_r8: assert property (@(posedge clk) disable iff (rst)
        wr.en |-> (wr.addr <= LAST));

    p_write_lands_r5: assert property (@(posedge clk) disable iff (rst)
        wr.en |=> (regs_flat[int'($past(wr.addr))*DATA_W +: DATA_W] == $past(wr.data)));
endmodule

bind i2c_regwrite_slave i2cw_checker #(.NREG(NREG)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .sda_oe    (sda_oe),
    .ev        (ev),
    .phase     (phase),
    .wr        (wr),
    .regs_flat (regs_flat)
);

// File: tb/i2c_regwrite_slave_bench.sv
`timescale 1ns/1ps
module i2c_regwrite_slave_bench;

    localparam logic [6:0] DEV = 7'h48;
    localparam int         NR  = 9;
    localparam int         Q   = 10;

    typedef struct packed {
        logic [7:0] ptr_b;
        logic [7:0] data;
    } vec_t;

    localparam vec_t VECS [5] = '{
        '{ptr_b: 8'h00, data: 8'hA5},
        '{ptr_b: 8'h03, data: 8'h3C},
        '{ptr_b: 8'hE5, data: 8'h5A},
        '{ptr_b: 8'h68, data: 8'hFF},
        '{ptr_b: 8'h27, data: 8'h81}
    };

    typedef logic [7:0] barr_t [8];

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_in;
    logic sda_oe;
    logic [NR*8-1:0] regs_flat;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    logic [7:0] model [NR];

    always #2.5 clk = ~clk;

    assign sda_in = sda_m & ~sda_oe;

    i2c_regwrite_slave #(.DEV_ADDR(DEV), .NREG(NR)) u_i2c_regwrite_slave (
        .clk       (clk),
        .rst       (rst),
        .scl_in    (scl_m),
        .sda_in    (sda_in),
        .sda_oe    (sda_oe),
        .regs_flat (regs_flat)
    );

    task automatic check(input bit ok, input string req,
                         input logic [71:0] act, input logic [71:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic waitq(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    function automatic logic [NR*8-1:0] model_flat();
        logic [NR*8-1:0] f;
        for (int i = 0; i < NR; i++) f[i*8 +: 8] = model[i];
        return f;
    endfunction

    task automatic check_regs(input string req);
        waitq(Q);
        check(regs_flat == model_flat(), req, 72'(regs_flat), 72'(model_flat()));
    endtask

    task automatic bus_start();
        sda_m = 1'b1; waitq(Q);
        scl_m = 1'b1; waitq(Q);
        sda_m = 1'b0; waitq(Q);
        scl_m = 1'b0; waitq(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; waitq(Q);
        scl_m = 1'b1; waitq(Q);
        sda_m = 1'b1; waitq(Q);
    endtask

    task automatic send_bits(input logic [7:0] b, input int nbits);
        for (int i = 7; i > 7 - nbits; i--) begin
            sda_m = b[i]; waitq(Q);
            scl_m = 1'b1; waitq(2*Q);
            scl_m = 1'b0; waitq(Q);
        end
    endtask

    // Sends a byte, returns whether the target pulled SDA low on the 9th clock
    task automatic send_byte(input logic [7:0] b, output bit acked);
        send_bits(b, 8);
        sda_m = 1'b1; waitq(Q);
        scl_m = 1'b1; waitq(Q);
        acked = (sda_oe == 1'b1);
        waitq(Q);
        scl_m = 1'b0; waitq(Q);
        check(sda_oe == 1'b0, "R10 release after ninth clock", 72'(sda_oe), 72'(0));
    endtask

    function automatic int model_step(input int p);
        return (p >= NR - 1) ? 0 : p + 1;
    endfunction

    task automatic write_txn(input logic [7:0] ptr_b, input barr_t d,
                             input int n, input string req);
        bit a;
        int p;
        bus_start();
        send_byte({DEV, 1'b0}, a);
        check(a, "R2 device ack", 72'(a), 72'(1));
        send_byte(ptr_b, a);
        check(a, "R4 pointer ack", 72'(a), 72'(1));
        p = int'(ptr_b[4:0]);
        for (int i = 0; i < n; i++) begin
            send_byte(d[i], a);
            check(a, "R5 data ack", 72'(a), 72'(1));
            if (p < NR) model[p] = d[i];
            p = model_step(p);
        end
        bus_stop();
        check_regs(req);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        bit a;
        for (int i = 0; i < NR; i++) model[i] = 8'h00;
        waitq(10);
        check(regs_flat == '0, "R1 regs zero in reset", 72'(regs_flat), 72'(0));
        check(sda_oe == 1'b0, "R1 sda_oe low in reset", 72'(sda_oe), 72'(0));
        rst = 1'b0;
        waitq(1);
        check(regs_flat == '0 && sda_oe == 1'b0, "R1 state after reset",
              72'(regs_flat), 72'(0));

        // Table walk: single-byte writes, upper pointer bits set in some rows (R4, R5)
        for (int v = 0; v < 5; v++) begin
            barr_t d;
            for (int i = 0; i < 8; i++) d[i] = 8'h00;
            d[0] = VECS[v].data;
            write_txn(VECS[v].ptr_b, d, 1, "R4 R5 table write");
        end

        // Burst from register 6: fills 6,7,8 then wraps to 0,1 (R6, R7)
        write_txn(8'h06, '{8'h11, 8'h22, 8'h33, 8'h44, 8'h55, 8'h00, 8'h00, 8'h00},
                  5, "R6 R7 burst with wrap");
        check(regs_flat[0 +: 8] == 8'h44, "R7 wrapped byte in reg0",
              72'(regs_flat[0 +: 8]), 72'(8'h44));

        // Pointer above the last register: byte discarded, next lands in reg0 (R8)
        write_txn(8'h1F, '{8'h99, 8'h77, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00},
                  2, "R8 out-of-range pointer");
        check(regs_flat[0 +: 8] == 8'h77, "R8 follow-on byte in reg0",
              72'(regs_flat[0 +: 8]), 72'(8'h77));

        // Wrong address: no ack, following bytes ignored (R3)
        bus_start();
        send_byte({DEV ^ 7'h01, 1'b0}, a);
        check(!a, "R3 wrong address not acked", 72'(a), 72'(0));
        send_byte(8'h02, a);
        check(!a, "R3 pointer after mismatch not acked", 72'(a), 72'(0));
        send_byte(8'hEE, a);
        check(!a, "R3 data after mismatch not acked", 72'(a), 72'(0));
        bus_stop();
        check_regs("R3 regs unchanged after mismatch");

        // Read direction: no ack (R3)
        bus_start();
        send_byte({DEV, 1'b1}, a);
        check(!a, "R3 read direction not acked", 72'(a), 72'(0));
        send_byte(8'h03, a);
        check(!a, "R3 byte after read request not acked", 72'(a), 72'(0));
        bus_stop();
        check_regs("R3 regs unchanged after read request");

        // Stop inside a data byte discards it (R9)
        bus_start();
        send_byte({DEV, 1'b0}, a);
        send_byte(8'h02, a);
        send_bits(8'hF0, 3);
        bus_stop();
        check_regs("R9 partial byte dropped on stop");

        // Repeated start inside a data byte restarts matching (R9)
        bus_start();
        send_byte({DEV, 1'b0}, a);
        send_byte(8'h04, a);
        send_bits(8'h0F, 4);
        bus_start();
        send_byte({DEV, 1'b0}, a);
        check(a, "R9 device ack after repeated start", 72'(a), 72'(1));
        send_byte(8'h04, a);
        send_byte(8'hC3, a);
        model[4] = 8'hC3;
        bus_stop();
        check_regs("R9 write after repeated start");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule